// File: doc/BRIEF.md
# DMA Transfer Mode Selector

This block chooses the fastest DMA transfer mode that a storage device and its host port can both use. It reads the device's identify information, which gives two validity flags, the supported-mode words for Ultra DMA, multiword DMA and single-word DMA, and a legacy single-word timing value. It combines these with the host's capability mask for each family, with a qualifier for device type and ATAPI DMA permission, and with a cable-detect input. The result is an 8-bit transfer-mode code. A code of zero means that no DMA mode is usable.

The families are tried in a fixed order, fastest first: Ultra, then multiword, then single-word. Within the first family that has any usable mode, the highest usable mode wins. Without an 80-conductor cable, the fast Ultra modes are removed. When the device gives no mode words, a small legacy timing value can still enable low single-word modes. Control logic pulses `calc_req` for one cycle. The chosen code is captured at that edge and `done` pulses in the next cycle.

Top module: `dma_mode_pick`

## Requirements
- R1: While `rst_n` is low at a clock edge, `mode_code` becomes 0x00 and `done` becomes 0.
- R2: `done` is high exactly in the cycle after a cycle with `calc_req` high. `mode_code` updates only on such a strobe and otherwise holds its value, whatever the other inputs do.
- R3: If the Ultra mask is non-empty, the code is 0x40 plus the index of its highest set bit. The Ultra mask is `udma_word & host_udma`, with bit n meaning Ultra mode n, for modes 0 to 6.
- R4: The Ultra mask is empty when `id_valid[2]` is 0.
- R5: When `cable80` is 0 and the Ultra mask has any of bits 6:3 set, only bits 2:0 are kept. The code is then at most 0x42, and is never 0x43 to 0x46.
- R6: If the Ultra mask is empty, `id_valid[1]` is 1 and `mw_word & host_mw` is non-empty, the code is 0x20 plus the index of the highest set bit, for modes 0 to 2.
- R7: If both faster masks are empty and the single-word mask is non-empty, the code is 0x10 plus the index of its highest set bit. With `id_valid[1]` set, the single-word mask is `sw_word & host_sw`.
- R8: With `id_valid[1]` clear, the mode words are ignored. A `legacy_tim` value of 1 gives a single-word mask of 3'b011 AND `host_sw`, and a value of 2 gives 3'b111 AND `host_sw`. A value of 0 or of 3 and above gives an empty mask.
- R9: With `is_disk` 0 and `atapi_dma_en` 0, the code is 0x00 whatever the other inputs are.
- R10: When all three masks are empty, the code is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| calc_req | input | 1 | One-cycle strobe that captures a new selection |
| id_valid | input | 2 | Identify validity flags: bit 2 validates the Ultra word, bit 1 validates the multiword and single-word words |
| udma_word | input | 7 | Ultra DMA modes the device supports |
| mw_word | input | 3 | Multiword DMA modes the device supports |
| sw_word | input | 3 | Single-word DMA modes the device supports |
| legacy_tim | input | 8 | Legacy single-word timing value |
| host_udma | input | 7 | Ultra modes the host allows |
| host_mw | input | 3 | Multiword modes the host allows |
| host_sw | input | 3 | Single-word modes the host allows |
| is_disk | input | 1 | Device is a disk |
| atapi_dma_en | input | 1 | DMA is allowed for non-disk devices |
| cable80 | input | 1 | 80-conductor cable detected |
| mode_code | output | 8 | Selected transfer-mode code, 0 if none |
| done | output | 1 | Pulses one cycle after each strobe |

## Verification
The main sweep runs every Ultra word against every multiword word, under all four combinations of validity flags and both cable states. This separates family priority, highest-bit selection, the validity gating and the cable cut. A second sweep crosses every single-word word with legacy timing values 0 to 4 and both states of `id_valid[1]`. It shows where the legacy fallback applies and that the timing value has no effect once the flag is set. Further sweeps walk the host masks to show that the AND is applied, and cross the device-type qualifiers with a rich identify set to show that R9 forces zero. A hold test changes every input without a strobe.

// File: rtl/dma_sel_pkg.sv
// Package: shared constants and types for the DMA mode selector.
// Assumes an 8-bit mode code whose upper nibble tells the family apart.
package dma_sel_pkg;
    localparam int CODE_W = 8;
    localparam logic [CODE_W-1:0] BASE_ULTRA  = 8'h40;
    localparam logic [CODE_W-1:0] BASE_MULTI  = 8'h20;
    localparam logic [CODE_W-1:0] BASE_SINGLE = 8'h10;

    typedef enum logic [1:0] {
        FAM_NONE   = 2'd0,
        FAM_ULTRA  = 2'd1,
        FAM_MULTI  = 2'd2,
        FAM_SINGLE = 2'd3
    } dma_family_e;
endpackage

// File: rtl/dma_fam_masks.sv
// Module: builds the usable-mode mask for each DMA family.
// Applies the validity gating, the host AND, the cable cut and the
// legacy single-word fallback. Purely combinational.
module dma_fam_masks #(
    parameter int UW     = 7,
    parameter int MW     = 3,
    parameter int SW     = 3,
    parameter int TIM_W  = 8,
    parameter int SLOW_U = 3,
    parameter int TIM_MAX = 2
) (
    input  logic [2:1]       id_valid,
    input  logic [UW-1:0]    udma_word,
    input  logic [MW-1:0]    mw_word,
    input  logic [SW-1:0]    sw_word,
    input  logic [TIM_W-1:0] legacy_tim,
    input  logic [UW-1:0]    host_udma,
    input  logic [MW-1:0]    host_mw,
    input  logic [SW-1:0]    host_sw,
    input  logic             cable80,
    output logic [UW-1:0]    u_mask,
    output logic [MW-1:0]    m_mask,
    output logic [SW-1:0]    s_mask
);
    logic [UW-1:0] u_raw;
    logic [UW-1:0] u_keep;
    logic          u_fast;
    logic [SW-1:0] tim_fill;
    logic          tim_ok;

    // Purpose: the modes that a 40-conductor cable still permits.
    generate
        for (genvar gi = 0; gi < UW; gi++) begin : g_keep
            assign u_keep[gi] = (gi < SLOW_U);
        end
    endgenerate

    // Purpose: gate the Ultra word and cut the fast modes without an 80-wire cable.
    always_comb begin
        u_raw  = id_valid[2] ? (udma_word & host_udma) : '0;
        u_fast = |(u_raw & ~u_keep);
        u_mask = (u_fast && !cable80) ? (u_raw & u_keep) : u_raw;
    end

    // Purpose: build the legacy fill pattern, with bits 0..tim set.
    always_comb begin
        tim_ok = (legacy_tim != '0) && (legacy_tim <= TIM_W'(TIM_MAX));
        for (int i = 0; i < SW; i++) begin
            tim_fill[i] = (TIM_W'(i) <= legacy_tim);
        end
    end

    // Purpose: multiword and single-word masks, with the legacy fallback.
    always_comb begin
        if (id_valid[1]) begin
            m_mask = mw_word & host_mw;
            s_mask = sw_word & host_sw;
        end else begin
            m_mask = '0;
            s_mask = tim_ok ? (tim_fill & host_sw) : '0;
        end
    end
endmodule

// File: rtl/dma_top_bit.sv
// Module: finds the highest set bit of a vector.
// Assumes W >= 1. The index is meaningful only when hit is 1.
module dma_top_bit #(
    parameter int W  = 7,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic          hit,
    output logic [IW-1:0] idx
);
    // Purpose: scan upward so that the last set bit seen is the highest.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/dma_code_pick.sv
// Module: picks the family by fixed priority and forms the mode code.
// Assumes each index is below 16, so base + index stays in its nibble.
module dma_code_pick
    import dma_sel_pkg::*;
#(
    parameter int UIW = 3,
    parameter int MIW = 2,
    parameter int SIW = 2
) (
    input  logic              media_ok,
    input  logic              u_hit,
    input  logic [UIW-1:0]    u_idx,
    input  logic              m_hit,
    input  logic [MIW-1:0]    m_idx,
    input  logic              s_hit,
    input  logic [SIW-1:0]    s_idx,
    output logic [CODE_W-1:0] code
);
    dma_family_e fam;

    // Purpose: fixed family priority, Ultra first, with the media veto on top.
    always_comb begin
        if (!media_ok)  fam = FAM_NONE;
        else if (u_hit) fam = FAM_ULTRA;
        else if (m_hit) fam = FAM_MULTI;
        else if (s_hit) fam = FAM_SINGLE;
        else            fam = FAM_NONE;
    end

    // Purpose: add the winning index to its family base.
    always_comb begin
        unique case (fam)
            FAM_ULTRA:  code = BASE_ULTRA  + CODE_W'(u_idx);
            FAM_MULTI:  code = BASE_MULTI  + CODE_W'(m_idx);
            FAM_SINGLE: code = BASE_SINGLE + CODE_W'(s_idx);
            default:    code = '0;
        endcase
    end
endmodule

// File: rtl/dma_mode_pick.sv
// Module: top of the DMA transfer-mode selector.
// Computes the best mode combinationally and captures it on calc_req.
// done pulses in the cycle after the strobe. Reset is synchronous and active low.
module dma_mode_pick
    import dma_sel_pkg::*;
#(
    parameter int UW      = 7,
    parameter int MW      = 3,
    parameter int SW      = 3,
    parameter int TIM_W   = 8,
    parameter int SLOW_U  = 3,
    parameter int TIM_MAX = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              calc_req,
    input  logic [2:1]        id_valid,
    input  logic [UW-1:0]     udma_word,
    input  logic [MW-1:0]     mw_word,
    input  logic [SW-1:0]     sw_word,
    input  logic [TIM_W-1:0]  legacy_tim,
    input  logic [UW-1:0]     host_udma,
    input  logic [MW-1:0]     host_mw,
    input  logic [SW-1:0]     host_sw,
    input  logic              is_disk,
    input  logic              atapi_dma_en,
    input  logic              cable80,
    output logic [CODE_W-1:0] mode_code,
    output logic              done
);
    localparam int UIW = (UW > 1) ? $clog2(UW) : 1;
    localparam int MIW = (MW > 1) ? $clog2(MW) : 1;
    localparam int SIW = (SW > 1) ? $clog2(SW) : 1;

    logic [UW-1:0]     u_mask;
    logic [MW-1:0]     m_mask;
    logic [SW-1:0]     s_mask;
    logic              u_hit, m_hit, s_hit;
    logic [UIW-1:0]    u_idx;
    logic [MIW-1:0]    m_idx;
    logic [SIW-1:0]    s_idx;
    logic [CODE_W-1:0] next_code;
    logic              media_ok;

    assign media_ok = is_disk | atapi_dma_en;

    dma_fam_masks #(
        .UW(UW), .MW(MW), .SW(SW), .TIM_W(TIM_W),
        .SLOW_U(SLOW_U), .TIM_MAX(TIM_MAX)
    ) u_masks (
        .id_valid(id_valid), .udma_word(udma_word), .mw_word(mw_word),
        .sw_word(sw_word), .legacy_tim(legacy_tim), .host_udma(host_udma),
        .host_mw(host_mw), .host_sw(host_sw), .cable80(cable80),
        .u_mask(u_mask), .m_mask(m_mask), .s_mask(s_mask)
    );

    dma_top_bit #(.W(UW)) u_top_u (.vec(u_mask), .hit(u_hit), .idx(u_idx));
    dma_top_bit #(.W(MW)) u_top_m (.vec(m_mask), .hit(m_hit), .idx(m_idx));
    dma_top_bit #(.W(SW)) u_top_s (.vec(s_mask), .hit(s_hit), .idx(s_idx));

    dma_code_pick #(.UIW(UIW), .MIW(MIW), .SIW(SIW)) u_pick (
        .media_ok(media_ok),
        .u_hit(u_hit), .u_idx(u_idx),
        .m_hit(m_hit), .m_idx(m_idx),
        .s_hit(s_hit), .s_idx(s_idx),
        .code(next_code)
    );

    // Purpose: capture the selection on a strobe and pulse done one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_code <= '0;
            done      <= 1'b0;
        end else begin
            done <= calc_req;
            if (calc_req) begin
                mode_code <= next_code;
            end
        end
    end
endmodule

// File: rtl/dma_mode_pick_chk.sv
// Module: checker holding the temporal properties of the selector.
// Bound to every instance of dma_mode_pick. It only observes.
module dma_mode_pick_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          calc_req,
    input logic [2:1]    id_valid,
    input logic          is_disk,
    input logic          atapi_dma_en,
    input logic          cable80,
    input logic [CW-1:0] mode_code,
    input logic          done
);
    assert_done_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        calc_req |=> done);
    assert_no_spurious_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !calc_req |=> !done);
    assert_code_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !calc_req |=> $stable(mode_code));
    assert_one_family_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mode_code[6:4]) && !mode_code[7]);
    assert_ultra_needs_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        calc_req && !id_valid[2] |=> mode_code[7:4] != 4'h4);
    assert_cable_cut_R5: assert property (@(posedge clk) disable iff (!rst_n)
        calc_req && !cable80 |=> !(mode_code[7:4] == 4'h4 && mode_code[3:0] > 4'h2));
    assert_multi_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        calc_req && !id_valid[1] |=> mode_code[7:4] != 4'h2);
    assert_media_veto_R9: assert property (@(posedge clk) disable iff (!rst_n)
        calc_req && !is_disk && !atapi_dma_en |=> mode_code == '0);
endmodule

bind dma_mode_pick dma_mode_pick_chk #(.CW(dma_sel_pkg::CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .calc_req(calc_req), .id_valid(id_valid),
    .is_disk(is_disk), .atapi_dma_en(atapi_dma_en), .cable80(cable80),
    .mode_code(mode_code), .done(done)
);

// File: tb/dma_mode_pick_tb.sv
module dma_mode_pick_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       calc_req = 1'b0;
    logic [2:1] id_valid = '0;
    logic [6:0] udma_word = '0, host_udma = '0;
    logic [2:0] mw_word = '0, host_mw = '0, sw_word = '0, host_sw = '0;
    logic [7:0] legacy_tim = '0;
    logic       is_disk = 1'b1, atapi_dma_en = 1'b0, cable80 = 1'b0;
    logic [7:0] mode_code;
    logic       done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_mode_pick u_dut (
        .clk(clk), .rst_n(rst_n), .calc_req(calc_req), .id_valid(id_valid),
        .udma_word(udma_word), .mw_word(mw_word), .sw_word(sw_word),
        .legacy_tim(legacy_tim), .host_udma(host_udma), .host_mw(host_mw),
        .host_sw(host_sw), .is_disk(is_disk), .atapi_dma_en(atapi_dma_en),
        .cable80(cable80), .mode_code(mode_code), .done(done)
    );

    // Returns the highest set bit of v, or -1 when v is zero.
    function automatic int top_bit(input int v);
        int r = -1;
        for (int i = 0; i < 32; i++) if ((v >> i) & 1) r = i;
        return r;
    endfunction

    // Expected code, worked out from the requirements.
    function automatic int expect_code();
        int um, mm, sm, t;
        um = id_valid[2] ? (int'(udma_word) & int'(host_udma)) : 0;
        if ((um & 'h78) != 0 && !cable80) um = um & 7;
        mm = id_valid[1] ? (int'(mw_word) & int'(host_mw)) : 0;
        t = int'(legacy_tim);
        if (id_valid[1]) sm = int'(sw_word) & int'(host_sw);
        else if (t >= 1 && t <= 2) sm = ((2 << t) - 1) & int'(host_sw);
        else sm = 0;
        if (!is_disk && !atapi_dma_en) return 0;
        if (um != 0) return 'h40 + top_bit(um);
        if (mm != 0) return 'h20 + top_bit(mm);
        if (sm != 0) return 'h10 + top_bit(sm);
        return 0;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Strobe once with the current inputs, then check done and the code.
    task automatic run_one(input string tag);
        int e;
        e = expect_code();
        calc_req = 1'b1;
        @(negedge clk);
        calc_req = 1'b0;
        check("R2 done pulse", int'(done), 1);
        check(tag, int'(mode_code), e);
        @(negedge clk);
        check("R2 done low", int'(done), 0);
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        calc_req = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset code", int'(mode_code), 0);
        check("R1 reset done", int'(done), 0);
        calc_req = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // Main sweep: priority, highest bit, validity flags, cable cut.
        host_udma = 7'h7f; host_mw = 3'h7; host_sw = 3'h7; sw_word = 3'h5;
        for (int v = 0; v < 4; v++)
            for (int c = 0; c < 2; c++)
                for (int u = 0; u < 128; u++)
                    for (int m = 0; m < 8; m++) begin
                        id_valid = v[1:0]; cable80 = c[0];
                        udma_word = u[6:0]; mw_word = m[2:0];
                        run_one("R3 R4 R5 R6 R7 R10 family sweep");
                    end

        // Single-word and legacy timing fallback.
        udma_word = '0; mw_word = '0; host_sw = 3'h7;
        for (int v = 0; v < 2; v++)
            for (int s = 0; s < 8; s++)
                for (int t = 0; t < 5; t++) begin
                    id_valid = {1'b1, v[0]}; sw_word = s[2:0]; legacy_tim = t[7:0];
                    run_one("R7 R8 single-word and legacy");
                end
        id_valid = 2'b00; legacy_tim = 8'hff;
        run_one("R8 large timing ignored");
        legacy_tim = 8'd2; host_sw = 3'b101;
        run_one("R8 legacy with host mask");

        // Host masks are ANDed in.
        legacy_tim = '0;
        for (int c = 0; c < 2; c++)
            for (int h = 0; h < 128; h++) begin
                id_valid = 2'b11; cable80 = c[0]; udma_word = 7'h7f;
                host_udma = h[6:0]; mw_word = 3'h2; host_mw = 3'h6;
                run_one("R3 R5 host ultra mask");
            end

        // Device-type veto.
        host_udma = 7'h7f; host_mw = 3'h7; host_sw = 3'h7;
        udma_word = 7'h3f; mw_word = 3'h7; sw_word = 3'h7; cable80 = 1'b1;
        for (int d = 0; d < 4; d++) begin
            is_disk = d[0]; atapi_dma_en = d[1];
            run_one("R9 media qualifier");
        end
        is_disk = 1'b0; atapi_dma_en = 1'b0; udma_word = '0; legacy_tim = 8'd1;
        id_valid = 2'b00;
        run_one("R9 veto over legacy");

        // Hold without a strobe.
        is_disk = 1'b1; id_valid = 2'b11; udma_word = 7'h04; legacy_tim = '0;
        run_one("R3 hold setup");
        udma_word = 7'h40; mw_word = 3'h1; id_valid = 2'b00; cable80 = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 code held", int'(mode_code), 'h42);
        check("R2 no done", int'(done), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule